// File: doc/BRIEF.md
# Ordered Store-Merging Write Buffer

This block sits between a processor's store port and a memory bus. It holds a small circular queue of word-aligned entries. Each entry has a byte-enable mask that records which lanes hold data. A normal-memory store that hits a word already waiting in the queue is folded into that entry, so the bus sees fewer and wider writes. A store marked as a device-region access always gets an entry of its own. That entry leaves the block as exactly one bus access, with the byte enables of the store's own size. Entries drain strictly oldest first, so device accesses keep their count, their sizes and their relative order.

Loads consult the queue. A normal load gets a per-byte forwarding mask and data from the youngest queued normal entry that holds each byte of the addressed word. A device load is never forwarded. It is held back, by its ready signal, until no device entry remains in the queue.

The drain side is a plain request/acknowledge port. The head entry is offered while the queue is non-empty, and it is removed on the cycle the acknowledge is seen. The queue depth must be a power of two, at least 2.

Top module: `store_merge_wbuf`

## Requirements
- R1: After reset the queue is empty: `busReq` is low, `stReady` is high, and a normal load sees `ldFwdMask` = 0.
- R2: Store data is right-aligned on `stData`. `stSize` 0 writes a byte to lane `stAddr[1:0]`. `stSize` 1 writes a halfword to lanes 1:0 when `stAddr[1]` = 0 and to lanes 3:2 when it is 1. `stSize` 2 or 3 writes all four lanes. Lane n is `busData[8n+7:8n]` and bit n of `busBe`. The bus word address is `stAddr[ADDR_W-1:2]`.
- R3: A normal store is merged into the youngest queued normal entry with the same word address, other than the head entry. The merge ORs in the new byte enables, and new bytes overwrite old ones.
- R4: A store that merges is accepted (`stReady` high) even when all entries are occupied.
- R5: With all entries occupied, a store that cannot merge sees `stReady` low and is not lost. A store to the word of the head entry never merges, so it waits for a free entry.
- R6: A device store is never merged with any entry, and no later store merges into it. Four device byte stores to consecutive addresses drain as four accesses, each with one byte enable, in issue order.
- R7: Entries drain oldest first, one entry per request/acknowledge pair. Address, enables, data and device flag stay unchanged while `busReq` is high and `busAck` is low.
- R8: A normal load sets bit n of `ldFwdMask` when a queued normal entry for that word holds byte n. The lane then carries the value from the youngest such entry. Device entries are never forwarded.
- R9: A device load gets `ldFwdMask` = 0. Its `ldReady` stays low while any device entry is queued and goes high once none remains. Normal loads always see `ldReady` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request valid |
| stReady | output | 1 | Store accepted on this cycle when high with stValid |
| stAddr | input | ADDR_W | Store byte address |
| stSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| stData | input | 32 | Right-aligned store data |
| stDevice | input | 1 | Store targets a device region |
| ldValid | input | 1 | Load lookup valid |
| ldAddr | input | ADDR_W | Load byte address |
| ldDevice | input | 1 | Load targets a device region |
| ldReady | output | 1 | Load may be issued to memory |
| ldFwdMask | output | 4 | Bytes supplied from the queue |
| ldFwdData | output | 32 | Forwarded byte lanes |
| busReq | output | 1 | Head entry offered to the bus |
| busAck | input | 1 | Bus took the offered entry |
| busWordAddr | output | ADDR_W-2 | Word address of the offered entry |
| busBe | output | 4 | Byte enables of the offered entry |
| busData | output | 32 | Lane data of the offered entry |
| busDevice | output | 1 | Offered entry is a device access |

## Verification
The bench builds the block with four entries and an 8-bit byte address. This makes a full queue, merging while full, and a blocked store easy to reach within a few stores. A sweep runs every size against every byte offset and compares enables and lanes with values computed in the bench. Directed sequences cover several cases: a newer entry behind the head for the same word, a youngest-wins forwarding case, and four device byte stores drained one by one.

// File: rtl/smwb_pkg.sv
package smwb_pkg;
  // Strobes from the queue control to the entry datapath.
  typedef struct packed {
    logic push;   // write the store into the tail entry
    logic merge;  // fold the store into the chosen entry
    logic pop;    // retire the head entry
  } wbStrobe_t;

  localparam int unsigned LANES = 4;
  localparam int unsigned DATA_W = 32;
endpackage

// File: rtl/smwb_ctrl.sv
module smwb_ctrl
  import smwb_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             stDevice,
  input  logic [DEPTH-1:0] matchVec,
  input  logic             busAck,
  output wbStrobe_t        strobe,
  output logic [$clog2(DEPTH)-1:0] tailIdx,
  output logic [$clog2(DEPTH)-1:0] mergeIdx,
  output logic [$clog2(DEPTH)-1:0] headIdx,
  output logic [DEPTH-1:0] liveMask,
  output logic             stReady,
  output logic             busReq
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [PW-1:0] headQ, tailQ;
  logic [PW:0]   countQ;
  logic          full, mergeFound, canMerge;

  assign full    = (countQ == (PW+1)'(DEPTH));
  assign busReq  = (countQ != '0);
  assign headIdx = headQ;
  assign tailIdx = tailQ;

  // Which physical entries are occupied
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] offset;
      offset = PW'(i) - headQ;
      liveMask[i] = ({1'b0, offset} < countQ);
    end
  end

  // Youngest matching entry, skipping the head that is on the bus
  always_comb begin
    mergeFound = 1'b0;
    mergeIdx   = '0;
    for (int k = 1; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = headQ + PW'(k);
      if (((PW+1)'(k) < countQ) && matchVec[idx]) begin
        mergeFound = 1'b1;
        mergeIdx   = idx;
      end
    end
  end

  assign canMerge     = !stDevice && mergeFound;
  assign stReady      = !full || canMerge;
  assign strobe.push  = stValid && stReady && !canMerge;
  assign strobe.merge = stValid && canMerge;
  assign strobe.pop   = busReq && busAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      if (strobe.push) tailQ <= tailQ + 1'b1;
      if (strobe.pop)  headQ <= headQ + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end
endmodule

// File: rtl/smwb_data.sv
module smwb_data
  import smwb_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wbStrobe_t                strobe,
  input  logic [$clog2(DEPTH)-1:0] tailIdx,
  input  logic [$clog2(DEPTH)-1:0] mergeIdx,
  input  logic [$clog2(DEPTH)-1:0] headIdx,
  input  logic [DEPTH-1:0]         liveMask,
  input  logic [ADDR_W-1:0]        stAddr,
  input  logic [1:0]               stSize,
  input  logic [DATA_W-1:0]        stData,
  input  logic                     stDevice,
  input  logic                     ldValid,
  input  logic [ADDR_W-1:0]        ldAddr,
  input  logic                     ldDevice,
  output logic [DEPTH-1:0]         matchVec,
  output logic                     devPending,
  output logic [LANES-1:0]         ldFwdMask,
  output logic [DATA_W-1:0]        ldFwdData,
  output logic [ADDR_W-3:0]        busWordAddr,
  output logic [LANES-1:0]         busBe,
  output logic [DATA_W-1:0]        busData,
  output logic                     busDevice
);
  localparam int unsigned PW   = $clog2(DEPTH);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic [WA_W-1:0]   wordQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [LANES-1:0]  beQ   [DEPTH];
  logic [DEPTH-1:0]  devQ;

  logic [LANES-1:0]  stBe;
  logic [DATA_W-1:0] stLanes;
  logic [WA_W-1:0]   stWord, ldWord;

  assign stWord = stAddr[ADDR_W-1:2];
  assign ldWord = ldAddr[ADDR_W-1:2];

  // Lane steering: replicate, the enables pick the lanes
  always_comb begin
    case (stSize)
      2'd0: begin
        stBe    = 4'b0001 << stAddr[1:0];
        stLanes = {4{stData[7:0]}};
      end
      2'd1: begin
        stBe    = stAddr[1] ? 4'b1100 : 4'b0011;
        stLanes = {2{stData[15:0]}};
      end
      default: begin
        stBe    = 4'b1111;
        stLanes = stData;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        wordQ[i] <= '0;
        dataQ[i] <= '0;
        beQ[i]   <= '0;
      end
      devQ <= '0;
    end else if (strobe.push) begin
      wordQ[tailIdx] <= stWord;
      dataQ[tailIdx] <= stLanes;
      beQ[tailIdx]   <= stBe;
      devQ[tailIdx]  <= stDevice;
    end else if (strobe.merge) begin
      for (int b = 0; b < LANES; b++)
        if (stBe[b]) dataQ[mergeIdx][8*b +: 8] <= stLanes[8*b +: 8];
      beQ[mergeIdx] <= beQ[mergeIdx] | stBe;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_match
      assign matchVec[i] = (wordQ[i] == stWord) && !devQ[i];
    end
  endgenerate

  assign devPending = |(devQ & liveMask);

  // Forwarding walks oldest to youngest so younger bytes win
  always_comb begin
    ldFwdMask = '0;
    ldFwdData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = headIdx + PW'(k);
      if (liveMask[idx] && !devQ[idx] && (wordQ[idx] == ldWord)) begin
        for (int b = 0; b < LANES; b++) begin
          if (beQ[idx][b]) begin
            ldFwdMask[b]          = 1'b1;
            ldFwdData[8*b +: 8]   = dataQ[idx][8*b +: 8];
          end
        end
      end
    end
    if (!ldValid || ldDevice) begin
      ldFwdMask = '0;
      ldFwdData = '0;
    end
  end

  assign busWordAddr = wordQ[headIdx];
  assign busBe       = beQ[headIdx];
  assign busData     = dataQ[headIdx];
  assign busDevice   = devQ[headIdx];
endmodule

// File: rtl/store_merge_wbuf.sv
module store_merge_wbuf
  import smwb_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic [31:0]       stData,
  input  logic              stDevice,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              ldDevice,
  output logic              ldReady,
  output logic [3:0]        ldFwdMask,
  output logic [31:0]       ldFwdData,
  output logic              busReq,
  input  logic              busAck,
  output logic [ADDR_W-3:0] busWordAddr,
  output logic [3:0]        busBe,
  output logic [31:0]       busData,
  output logic              busDevice
);
  localparam int unsigned PW = $clog2(DEPTH);

  wbStrobe_t        strobe;
  logic [PW-1:0]    tailIdx, mergeIdx, headIdx;
  logic [DEPTH-1:0] liveMask, matchVec;
  logic             devPending;

  smwb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stDevice(stDevice),
    .matchVec(matchVec), .busAck(busAck), .strobe(strobe),
    .tailIdx(tailIdx), .mergeIdx(mergeIdx), .headIdx(headIdx),
    .liveMask(liveMask), .stReady(stReady), .busReq(busReq)
  );

  smwb_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tailIdx(tailIdx),
    .mergeIdx(mergeIdx), .headIdx(headIdx), .liveMask(liveMask),
    .stAddr(stAddr), .stSize(stSize), .stData(stData), .stDevice(stDevice),
    .ldValid(ldValid), .ldAddr(ldAddr), .ldDevice(ldDevice),
    .matchVec(matchVec), .devPending(devPending),
    .ldFwdMask(ldFwdMask), .ldFwdData(ldFwdData),
    .busWordAddr(busWordAddr), .busBe(busBe), .busData(busData),
    .busDevice(busDevice)
  );

  assign ldReady = !(ldDevice && devPending);
endmodule

// File: rtl/smwb_checker.sv
module smwb_checker #(
  parameter int unsigned WA_W = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            stReady,
  input logic            ldValid,
  input logic            ldDevice,
  input logic            ldReady,
  input logic            busReq,
  input logic            busAck,
  input logic [WA_W-1:0] busWordAddr,
  input logic [3:0]      busBe,
  input logic [31:0]     busData,
  input logic            busDevice
);
  // R7: an offered entry does not change until it is taken
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busWordAddr) && $stable(busBe)
                          && $stable(busData) && $stable(busDevice));

  // R7: every offered entry carries at least one byte
  a_r7_be_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busBe != 4'b0000);

  // R5: a refused store means the queue holds entries
  a_r5_full_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    !stReady |-> busReq);

  // R6: a device access keeps the shape of a single store
  a_r6_dev_be_shape: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busDevice |-> (busBe inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                           4'b0011, 4'b1100, 4'b1111}));

  // R9: a device load waits while a device entry is on the bus
  a_r9_dev_load_wait: assert property (@(posedge clk) disable iff (!rstN)
    ldValid && ldDevice && busReq && busDevice |-> !ldReady);
endmodule

bind store_merge_wbuf smwb_checker #(.WA_W(ADDR_W-2)) u_chk (
  .clk(clk), .rstN(rstN), .stReady(stReady), .ldValid(ldValid),
  .ldDevice(ldDevice), .ldReady(ldReady), .busReq(busReq), .busAck(busAck),
  .busWordAddr(busWordAddr), .busBe(busBe), .busData(busData),
  .busDevice(busDevice)
);

// File: tb/store_merge_wbuf_tb.sv
module store_merge_wbuf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              stValid = 1'b0;
  logic              stReady;
  logic [ADDR_W-1:0] stAddr = '0;
  logic [1:0]        stSize = '0;
  logic [31:0]       stData = '0;
  logic              stDevice = 1'b0;
  logic              ldValid = 1'b0;
  logic [ADDR_W-1:0] ldAddr = '0;
  logic              ldDevice = 1'b0;
  logic              ldReady;
  logic [3:0]        ldFwdMask;
  logic [31:0]       ldFwdData;
  logic              busReq;
  logic              busAck = 1'b0;
  logic [ADDR_W-3:0] busWordAddr;
  logic [3:0]        busBe;
  logic [31:0]       busData;
  logic              busDevice;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_merge_wbuf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (.*);

  function automatic logic [31:0] laneMask(logic [3:0] be);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [3:0] expBe(logic [1:0] sz, logic [1:0] off);
    if (sz == 2'd0) return 4'b0001 << off;
    if (sz == 2'd1) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] expLanes(logic [1:0] sz, logic [1:0] off, logic [31:0] d);
    if (sz == 2'd0) return {24'd0, d[7:0]} << (8 * off);
    if (sz == 2'd1) return {16'd0, d[15:0]} << (off[1] ? 16 : 0);
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doStore(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                         input logic [31:0] d, input logic dev);
    @(negedge clk);
    stAddr = a; stSize = sz; stData = d; stDevice = dev; stValid = 1'b1;
    #1;
    while (!stReady) begin @(negedge clk); #1; end
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic probeReady(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                            input logic dev, input logic exp, input string req);
    @(negedge clk);
    stAddr = a; stSize = sz; stData = 32'h0; stDevice = dev; stValid = 1'b1;
    #1;
    check(stReady == exp, req, "stReady", {31'd0, stReady}, {31'd0, exp});
    stValid = 1'b0;
    #1;
  endtask

  task automatic probeLoad(input logic [ADDR_W-1:0] a, input logic dev,
                           input logic [3:0] mask, input logic [31:0] d,
                           input logic rdy, input string req);
    @(negedge clk);
    ldAddr = a; ldDevice = dev; ldValid = 1'b1;
    #1;
    check(ldFwdMask == mask, req, "ldFwdMask", {28'd0, ldFwdMask}, {28'd0, mask});
    check((ldFwdData & laneMask(mask)) == d, req, "ldFwdData",
          ldFwdData & laneMask(mask), d);
    check(ldReady == rdy, req, "ldReady", {31'd0, ldReady}, {31'd0, rdy});
    ldValid = 1'b0; ldDevice = 1'b0;
  endtask

  task automatic drainOne(input logic [ADDR_W-3:0] wa, input logic [3:0] be,
                          input logic [31:0] d, input logic dev, input string req);
    @(negedge clk);
    #1;
    check(busReq == 1'b1, req, "busReq", {31'd0, busReq}, 32'd1);
    check(busWordAddr == wa, req, "busWordAddr", {26'd0, busWordAddr}, {26'd0, wa});
    check(busBe == be, req, "busBe", {28'd0, busBe}, {28'd0, be});
    check((busData & laneMask(be)) == d, req, "busData", busData & laneMask(be), d);
    check(busDevice == dev, req, "busDevice", {31'd0, busDevice}, {31'd0, dev});
    busAck = 1'b1;
    @(negedge clk);
    busAck = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check(busReq == 1'b0, "R1", "busReq", {31'd0, busReq}, 32'd0);
    check(stReady == 1'b1, "R1", "stReady", {31'd0, stReady}, 32'd1);
    probeLoad(8'h40, 1'b0, 4'b0000, 32'd0, 1'b1, "R1");

    // R2: sweep every size over every byte offset
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 4; off++) begin
        logic [ADDR_W-1:0] a;
        logic [31:0] d;
        a = 8'hA0 + ADDR_W'(off);
        d = 32'h8765_4321 ^ (32'(sz) << 8) ^ 32'(off * 16'h1111);
        doStore(a, 2'(sz), d, 1'b0);
        probeLoad(a, 1'b0, expBe(2'(sz), 2'(off)),
                  expLanes(2'(sz), 2'(off), d), 1'b1, "R2");
        drainOne(a[ADDR_W-1:2], expBe(2'(sz), 2'(off)),
                 expLanes(2'(sz), 2'(off), d), 1'b0, "R2");
      end
    end

    // R3/R4/R5/R6: fill the queue with busAck held low
    doStore(8'h40, 2'd0, 32'h11, 1'b0);        // head entry
    doStore(8'h80, 2'd1, 32'hBBAA, 1'b0);      // new entry
    doStore(8'h82, 2'd1, 32'hDDCC, 1'b0);      // R3 merge
    doStore(8'h90, 2'd0, 32'h01, 1'b1);        // device
    doStore(8'h91, 2'd0, 32'h02, 1'b1);        // device, queue now full
    probeReady(8'h83, 2'd0, 1'b0, 1'b1, "R4"); // merge while full
    doStore(8'h83, 2'd0, 32'hEE, 1'b0);
    probeReady(8'h92, 2'd0, 1'b1, 1'b0, "R5"); // device cannot merge
    probeReady(8'h41, 2'd0, 1'b0, 1'b0, "R5"); // head word never merges
    probeLoad(8'h80, 1'b0, 4'b1111, 32'hEECC_BBAA, 1'b1, "R3");
    probeLoad(8'h40, 1'b0, 4'b0001, 32'h11, 1'b1, "R8");
    probeLoad(8'h90, 1'b1, 4'b0000, 32'd0, 1'b0, "R9");
    probeLoad(8'h90, 1'b0, 4'b0000, 32'd0, 1'b1, "R8");
    probeLoad(8'h50, 1'b0, 4'b0000, 32'd0, 1'b1, "R8");
    drainOne(6'h10, 4'b0001, 32'h11, 1'b0, "R7");
    drainOne(6'h20, 4'b1111, 32'hEECC_BBAA, 1'b0, "R7");
    drainOne(6'h24, 4'b0001, 32'h01, 1'b1, "R6");
    probeLoad(8'h90, 1'b1, 4'b0000, 32'd0, 1'b0, "R9");
    drainOne(6'h24, 4'b0010, 32'h0200, 1'b1, "R6");
    doStore(8'h92, 2'd0, 32'h03, 1'b1);
    doStore(8'h93, 2'd0, 32'h04, 1'b1);
    drainOne(6'h24, 4'b0100, 32'h0003_0000, 1'b1, "R6");
    drainOne(6'h24, 4'b1000, 32'h0400_0000, 1'b1, "R6");
    @(negedge clk); #1;
    check(busReq == 1'b0, "R7", "busReq empty", {31'd0, busReq}, 32'd0);
    probeLoad(8'h90, 1'b1, 4'b0000, 32'd0, 1'b1, "R9");

    // R5/R8: same word behind the head gets a new entry, youngest byte wins
    doStore(8'h60, 2'd1, 32'h1111, 1'b0);
    doStore(8'h60, 2'd0, 32'h22, 1'b0);
    probeLoad(8'h60, 1'b0, 4'b0011, 32'h1122, 1'b1, "R8");
    drainOne(6'h18, 4'b0011, 32'h1111, 1'b0, "R5");
    drainOne(6'h18, 4'b0001, 32'h22, 1'b0, "R5");

    // R3: newer bytes overwrite merged lanes
    doStore(8'h00, 2'd0, 32'h5A, 1'b0);
    doStore(8'h74, 2'd2, 32'hAABB_CCDD, 1'b0);
    doStore(8'h75, 2'd0, 32'h99, 1'b0);
    probeLoad(8'h76, 1'b0, 4'b1111, 32'hAABB_99DD, 1'b1, "R3");
    drainOne(6'h00, 4'b0001, 32'h5A, 1'b0, "R7");
    drainOne(6'h1D, 4'b1111, 32'hAABB_99DD, 1'b0, "R3");

    // R6: device store to a queued normal word is not merged
    doStore(8'h00, 2'd0, 32'h5A, 1'b0);
    doStore(8'h34, 2'd1, 32'h7788, 1'b0);
    doStore(8'h36, 2'd1, 32'h3344, 1'b1);
    doStore(8'h37, 2'd0, 32'h55, 1'b0);
    drainOne(6'h00, 4'b0001, 32'h5A, 1'b0, "R7");
    drainOne(6'h0D, 4'b1011, 32'h5500_7788, 1'b0, "R3");
    drainOne(6'h0D, 4'b1100, 32'h3344_0000, 1'b1, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule